// File: doc/BRIEF.md
# Multi-Channel Shadowed Pulse-Width Modulator

This block produces several independent pulse-width-modulated outputs. A small synchronous register bus programs them. Each channel has the following parts:

- a free-running counter, advanced by its own power-of-two clock prescaler;
- a period length;
- an active window, given as a start count and a stop count;
- a pair of two-bit drive codes, one for the active phase and one for the inactive phase.

The drive codes choose whether the pin is driven high, driven low or released. This gives either polarity without extra logic. A global enable register selects which channels run. Set and clear aliases of that register let one channel be switched without disturbing the others.

Software writes the window register first and the period register second. The window write is only held in a staging copy. The period write marks both staged values as pending. A running channel copies the pending values into its working registers when its counter wraps to zero, so a period in progress never shows a half-applied setting. A stopped channel holds its counter at zero and takes pending values on the next clock.

Top module: `pwmsh_top`

## Requirements
- R1: After synchronous reset, all channel enables, staged registers and working registers are zero, and every `pwm_oe` and `pwm_out` bit is 0.
- R2: The register map has three enable addresses. A write to 0x00 loads the enable bits. A write to 0x04 sets the enable bits written as 1. A write to 0x08 clears the enable bits written as 1. Bits written as 0 at 0x04 or 0x08 are left unchanged, and a read of any of the three addresses returns the enable bits.
- R3: Channel n has its window register at address 0x20*(n+1) and its period register at 0x20*(n+1)+0x10. A read returns the staged value in the cycle after `bus_rd`. Period reads return only bits [22:0], and unmapped addresses read as 0.
- R4: The period register field [15:0] is the period length L. The counter runs 0..L-1 and then wraps. A length of 0 behaves as 1.
- R5: The period register field [22:20] selects the prescaler. Codes 0..7 advance the counter once every 1, 2, 4, 8, 16, 64, 256 and 1024 clocks respectively.
- R6: The window register holds a start count in [15:0] and a stop count in [31:16]. The channel is in its active phase while start <= count < stop.
- R7: The active-phase drive code is in period bits [17:16] and the inactive-phase drive code is in bits [19:18]. Code 3 drives the output high, code 2 drives it low, and codes 0 and 1 release it (`pwm_oe`=0, `pwm_out`=0).
- R8: A window write alone never changes the output of a running channel.
- R9: A period write makes the staged window and period pending. On a running channel they take effect in the first cycle of the next period, and never earlier.
- R10: A disabled channel has its counter held at 0 and its `pwm_oe`/`pwm_out` low from the cycle after its enable clears. Pending values are taken on the next clock while the channel is disabled.
- R11: Channels count, commit and drive independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pwm_out | output | NUM_CH | Output level per channel |
| pwm_oe | output | NUM_CH | Output drive enable per channel |

## Verification
Directed runs use fixed windows and count the high and driven cycles over one whole period, which makes the measurement independent of phase. These runs separate a window-only write from a committed period write, start at zero from start above zero, and normal drive codes from inverted and released ones. A slow prescaler with period length 2 makes a wrong divisor visible as a wrong count of high cycles. A long constrained-random phase issues window writes, period writes, enable set/clear operations and reads at random times against a cycle model in the bench. This exposes commits that land mid-period, wrong channel decode and one channel disturbing another.

// File: rtl/pwmsh_pkg.sv
package pwmsh_pkg;

    localparam int CH_STRIDE = 32;
    localparam int WIN_OFS   = 0;
    localparam int PER_OFS   = 16;
    localparam int CTRL_OFS  = 0;
    localparam int SET_OFS   = 4;
    localparam int CLR_OFS   = 8;

    localparam int CNT_W = 16;
    localparam int SEL_W = 3;
    localparam int SH_W  = 4;
    localparam int PRE_W = 10;

    typedef logic [1:0] drive_code_t;

    typedef struct packed {
        logic [SEL_W-1:0] psel;
        drive_code_t      idle_drv;
        drive_code_t      act_drv;
        logic [CNT_W-1:0] len;
    } per_cfg_t;

    localparam int PER_CFG_W = $bits(per_cfg_t);

    typedef struct packed {
        logic [CNT_W-1:0] stop;
        logic [CNT_W-1:0] start;
    } win_cfg_t;

    typedef struct packed {
        logic oe;
        logic lvl;
    } pin_t;

    function automatic logic [SH_W-1:0] sel_to_shift(logic [SEL_W-1:0] s);
        case (s)
            3'd5:    return SH_W'(6);
            3'd6:    return SH_W'(8);
            3'd7:    return SH_W'(10);
            default: return SH_W'(s);
        endcase
    endfunction

    function automatic pin_t decode_drive(drive_code_t c);
        pin_t p;
        p.oe  = c[1];
        p.lvl = c[1] & c[0];
        return p;
    endfunction

endpackage

// File: rtl/pwmsh_regs.sv
module pwmsh_regs
    import pwmsh_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic [NUM_CH-1:0]       ch_en,
    output win_cfg_t [NUM_CH-1:0]   win_stage,
    output per_cfg_t [NUM_CH-1:0]   per_stage,
    output logic [NUM_CH-1:0]       commit
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(SET_OFS);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_OFS);

    logic [NUM_CH-1:0] wmask;
    logic [31:0]       rd_val;

    assign wmask = bus_wdata[NUM_CH-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_en <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CTRL)     ch_en <= wmask;
            else if (bus_addr == A_SET) ch_en <= ch_en | wmask;
            else if (bus_addr == A_CLR) ch_en <= ch_en & ~wmask;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_stage
        localparam logic [ADDR_W-1:0] A_WIN = ADDR_W'((g + 1) * CH_STRIDE + WIN_OFS);
        localparam logic [ADDR_W-1:0] A_PER = ADDR_W'((g + 1) * CH_STRIDE + PER_OFS);
        logic hit_win;
        assign hit_win   = bus_wr && (bus_addr == A_WIN);
        assign commit[g] = bus_wr && (bus_addr == A_PER);

        always_ff @(posedge clk) begin
            if (rst) begin
                win_stage[g] <= '0;
                per_stage[g] <= '0;
            end else begin
                if (hit_win)   win_stage[g] <= win_cfg_t'(bus_wdata);
                if (commit[g]) per_stage[g] <= per_cfg_t'(bus_wdata[PER_CFG_W-1:0]);
            end
        end
    end

    always_comb begin
        rd_val = '0;
        if (bus_addr == A_CTRL || bus_addr == A_SET || bus_addr == A_CLR)
            rd_val[NUM_CH-1:0] = ch_en;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'((i + 1) * CH_STRIDE + WIN_OFS))
                rd_val = win_stage[i];
            if (bus_addr == ADDR_W'((i + 1) * CH_STRIDE + PER_OFS))
                rd_val = 32'(per_stage[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

endmodule

// File: rtl/pwmsh_presc.sv
module pwmsh_presc
    import pwmsh_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [SH_W-1:0] shift,
    output logic            tick
);

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] mask;

    assign mask = ~({PRE_W{1'b1}} << shift);
    assign tick = en && (pre == mask);

    always_ff @(posedge clk) begin
        if (rst || !en) pre <= '0;
        else if (tick)  pre <= '0;
        else            pre <= pre + 1'b1;
    end

endmodule

// File: rtl/pwmsh_chan.sv
module pwmsh_chan
    import pwmsh_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             commit,
    input  win_cfg_t         win_stage,
    input  per_cfg_t         per_stage,
    output logic [SH_W-1:0]  work_shift,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] eff_len,
    output logic             pwm_out,
    output logic             pwm_oe
);

    win_cfg_t work_win;
    per_cfg_t work_per;
    logic     pending;
    logic     wrap;
    logic     load;
    logic     active;
    pin_t     pin;

    assign eff_len    = (work_per.len == '0) ? CNT_W'(1) : work_per.len;
    assign work_shift = sel_to_shift(work_per.psel);
    assign wrap       = tick && (({1'b0, cnt} + 1'b1) >= {1'b0, eff_len});
    assign load       = pending && (!en || wrap);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            pending  <= 1'b0;
            work_win <= '0;
            work_per <= '0;
        end else begin
            if (!en)       cnt <= '0;
            else if (wrap) cnt <= '0;
            else if (tick) cnt <= cnt + 1'b1;
            if (load) begin
                work_win <= win_stage;
                work_per <= per_stage;
            end
            pending <= commit || (pending && !load);
        end
    end

    assign active  = (cnt >= work_win.start) && (cnt < work_win.stop);
    assign pin     = decode_drive(active ? work_per.act_drv : work_per.idle_drv);
    assign pwm_oe  = en && pin.oe;
    assign pwm_out = en && pin.lvl;

endmodule

// File: rtl/pwmsh_top.sv
module pwmsh_top
    import pwmsh_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [NUM_CH-1:0] pwm_oe
);

    logic [NUM_CH-1:0]             ch_en;
    logic [NUM_CH-1:0]             commit;
    win_cfg_t [NUM_CH-1:0]         win_stage;
    per_cfg_t [NUM_CH-1:0]         per_stage;
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt;
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_len;

    pwmsh_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ch_en     (ch_en),
        .win_stage (win_stage),
        .per_stage (per_stage),
        .commit    (commit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic            tick;
        logic [SH_W-1:0] shift;

        pwmsh_presc presc_i (
            .clk   (clk),
            .rst   (rst),
            .en    (ch_en[g]),
            .shift (shift),
            .tick  (tick)
        );

        pwmsh_chan chan_i (
            .clk        (clk),
            .rst        (rst),
            .en         (ch_en[g]),
            .tick       (tick),
            .commit     (commit[g]),
            .win_stage  (win_stage[g]),
            .per_stage  (per_stage[g]),
            .work_shift (shift),
            .cnt        (ch_cnt[g]),
            .eff_len    (ch_len[g]),
            .pwm_out    (pwm_out[g]),
            .pwm_oe     (pwm_oe[g])
        );
    end

endmodule

// File: rtl/pwmsh_checker.sv
module pwmsh_checker
    import pwmsh_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         bus_wr,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [31:0]                  bus_wdata,
    input logic [NUM_CH-1:0]            ch_en,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_len,
    input logic [NUM_CH-1:0]            pwm_oe
);

    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(SET_OFS);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(CLR_OFS);

    assert_set_alias_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_SET) |=>
            ((ch_en & $past(bus_wdata[NUM_CH-1:0])) == $past(bus_wdata[NUM_CH-1:0])));

    assert_clear_alias_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CLR) |=>
            ((ch_en & $past(bus_wdata[NUM_CH-1:0])) == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (rst)
            ch_cnt[g] < ch_len[g]);

        assert_len_only_at_wrap_R9: assert property (@(posedge clk) disable iff (rst)
            (ch_en[g] && ch_cnt[g] != '0) |-> $stable(ch_len[g]));

        assert_off_cnt_zero_R10: assert property (@(posedge clk) disable iff (rst)
            !ch_en[g] |=> (ch_cnt[g] == '0));

        assert_off_released_R10: assert property (@(posedge clk) disable iff (rst)
            !ch_en[g] |-> !pwm_oe[g]);
    end

endmodule

bind pwmsh_top pwmsh_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ch_en     (ch_en),
    .ch_cnt    (ch_cnt),
    .ch_len    (ch_len),
    .pwm_oe    (pwm_oe)
);

// File: tb/pwmsh_top_tb_top.sv
`timescale 1ns/1ps
module pwmsh_top_tb_top;

    localparam int NCH = 4;
    localparam int AW  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NCH-1:0] pwm_out;
    logic [NCH-1:0] pwm_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwmsh_top #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out),
        .pwm_oe    (pwm_oe)
    );

    // ---------------- reference model built from the requirements ----------------
    logic [31:0] m_wst [NCH];
    logic [31:0] m_pst [NCH];
    logic [31:0] m_wwk [NCH];
    logic [31:0] m_pwk [NCH];
    int          m_cnt [NCH];
    int          m_pre [NCH];
    bit          m_pend[NCH];
    logic [NCH-1:0] m_en;

    function automatic int div_of(logic [2:0] code);
        case (code)
            3'd0: return 1;    3'd1: return 2;   3'd2: return 4;   3'd3: return 8;
            3'd4: return 16;   3'd5: return 64;  3'd6: return 256; default: return 1024;
        endcase
    endfunction

    function automatic int base_of(int ch);
        return 32 * (ch + 1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = '0;
            for (int c = 0; c < NCH; c++) begin
                m_wst[c] = 0; m_pst[c] = 0; m_wwk[c] = 0; m_pwk[c] = 0;
                m_cnt[c] = 0; m_pre[c] = 0; m_pend[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                int  len;
                bit  ld;
                len = (m_pwk[c][15:0] == 0) ? 1 : int'(m_pwk[c][15:0]);
                ld  = 0;
                if (!m_en[c]) begin
                    m_cnt[c] = 0; m_pre[c] = 0; ld = m_pend[c];
                end else if (m_pre[c] == div_of(m_pwk[c][22:20]) - 1) begin
                    m_pre[c] = 0;
                    if (m_cnt[c] + 1 >= len) begin m_cnt[c] = 0; ld = m_pend[c]; end
                    else m_cnt[c] = m_cnt[c] + 1;
                end else begin
                    m_pre[c] = m_pre[c] + 1;
                end
                if (ld) begin m_wwk[c] = m_wst[c]; m_pwk[c] = m_pst[c]; m_pend[c] = 0; end
            end
            if (bus_wr) begin
                if (bus_addr == 8'h00) m_en = bus_wdata[NCH-1:0];
                else if (bus_addr == 8'h04) m_en = m_en | bus_wdata[NCH-1:0];
                else if (bus_addr == 8'h08) m_en = m_en & ~bus_wdata[NCH-1:0];
                for (int c = 0; c < NCH; c++) begin
                    if (int'(bus_addr) == base_of(c)) m_wst[c] = bus_wdata;
                    if (int'(bus_addr) == base_of(c) + 16) begin
                        m_pst[c] = bus_wdata & 32'h007F_FFFF; m_pend[c] = 1;
                    end
                end
            end
        end
    end

    function automatic logic [1:0] exp_pin(int c);
        logic [1:0] code;
        bit act;
        act  = (m_cnt[c] >= int'(m_wwk[c][15:0])) && (m_cnt[c] < int'(m_wwk[c][31:16]));
        code = act ? m_pwk[c][17:16] : m_pwk[c][19:18];
        return {m_en[c] && code[1], m_en[c] && code == 2'd3};
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison of every channel against the model (R4 R5 R6 R7 R9 R11)
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int c = 0; c < NCH; c++) begin
                logic [1:0] e;
                e = exp_pin(c);
                chk({pwm_oe[c], pwm_out[c]} == e, "R11 model pin compare",
                    32'({pwm_oe[c], pwm_out[c]}), 32'(e));
            end
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(int a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = AW'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic cfg(int ch, int start, int stop, int len, int act, int idle, int psel);
        wr(base_of(ch), {16'(stop), 16'(start)});
        wr(base_of(ch) + 16, {9'd0, 3'(psel), 2'(idle), 2'(act), 16'(len)});
    endtask

    int mhi[NCH];
    int moe[NCH];
    task automatic measure(int n);
        for (int c = 0; c < NCH; c++) begin mhi[c] = 0; moe[c] = 0; end
        for (int k = 0; k < n; k++) begin
            for (int c = 0; c < NCH; c++) begin
                mhi[c] += int'(pwm_out[c]);
                moe[c] += int'(pwm_oe[c]);
            end
            @(negedge clk);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_0417));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(pwm_oe == '0, "R1 oe after reset", 32'(pwm_oe), 0);
        chk(pwm_out == '0, "R1 out after reset", 32'(pwm_out), 0);
        rd(8'h00, d); chk(d == 0, "R1 enables after reset", d, 0);
        rd(8'h30, d); chk(d == 0, "R1 period stage after reset", d, 0);

        // R2 enable register and aliases
        wr(8'h00, 32'h5);      rd(8'h00, d); chk(d == 32'h5, "R2 direct write", d, 32'h5);
        wr(8'h04, 32'h2);      rd(8'h04, d); chk(d == 32'h7, "R2 set alias", d, 32'h7);
        wr(8'h08, 32'h4);      rd(8'h08, d); chk(d == 32'h3, "R2 clear alias", d, 32'h3);
        wr(8'h08, 32'hF);      rd(8'h00, d); chk(d == 32'h0, "R2 clear all", d, 32'h0);

        // R3 channel decode and readback
        wr(8'h60, 32'hABCD_1234); rd(8'h60, d); chk(d == 32'hABCD_1234, "R3 window readback ch2", d, 32'hABCD_1234);
        rd(8'h40, d); chk(d == 0, "R3 other channel untouched", d, 0);
        wr(8'h70, 32'hFFFF_FFFF); rd(8'h70, d); chk(d == 32'h007F_FFFF, "R3 period readback width", d, 32'h007F_FFFF);
        rd(8'h14, d); chk(d == 0, "R3 unmapped read", d, 0);

        // R6 basic window on ch0
        cfg(0, 0, 4, 10, 3, 2, 0);
        wr(8'h04, 32'h1);
        measure(10);
        chk(mhi[0] == 4, "R6 high count stop=4 len=10", mhi[0], 4);
        chk(moe[0] == 10, "R7 driven every cycle", moe[0], 10);

        // R8 window-only write has no effect
        wr(base_of(0), {16'd7, 16'd0});
        idle(25); measure(10);
        chk(mhi[0] == 4, "R8 window staged only", mhi[0], 4);

        // R9 period write commits at boundary
        wr(base_of(0) + 16, {9'd0, 3'd0, 2'd2, 2'd3, 16'd10});
        idle(12); measure(10);
        chk(mhi[0] == 7, "R9 commit after period write", mhi[0], 7);

        // R6 non-zero start, stop beyond length
        cfg(0, 5, 20, 10, 3, 2, 0);
        idle(12); measure(10);
        chk(mhi[0] == 5, "R6 start=5 stop>len", mhi[0], 5);

        // R7 inverted polarity and released code
        cfg(0, 0, 4, 10, 2, 3, 0);
        idle(12); measure(10);
        chk(mhi[0] == 6, "R7 inverted high count", mhi[0], 6);
        cfg(0, 0, 4, 10, 0, 3, 0);
        idle(12); measure(10);
        chk(moe[0] == 6, "R7 code0 releases pin", moe[0], 6);
        chk(mhi[0] == 6, "R7 code0 level", mhi[0], 6);

        // R4 length zero and one
        cfg(0, 0, 1, 0, 3, 2, 0);
        idle(12); measure(10);
        chk(mhi[0] == 10, "R4 length 0 acts as 1", mhi[0], 10);
        cfg(0, 1, 2, 1, 3, 2, 0);
        idle(4); measure(10);
        chk(mhi[0] == 0, "R4 length 1 count stays 0", mhi[0], 0);

        // R5 prescaler codes 5 and 7 on ch1
        cfg(1, 0, 1, 2, 3, 2, 5);
        wr(8'h04, 32'h2);
        measure(128);
        chk(mhi[1] == 64, "R5 code5 divides by 64", mhi[1], 64);
        wr(8'h08, 32'h2);
        cfg(1, 0, 1, 2, 3, 2, 7);
        wr(8'h04, 32'h2);
        measure(2048);
        chk(mhi[1] == 1024, "R5 code7 divides by 1024", mhi[1], 1024);
        wr(8'h08, 32'h2);

        // R10 disable and commit while disabled
        wr(8'h08, 32'h1);
        chk(pwm_oe[0] == 1'b0, "R10 oe low after disable", 32'(pwm_oe[0]), 0);
        measure(20);
        chk(moe[0] == 0, "R10 stays released", moe[0], 0);
        cfg(0, 0, 3, 5, 3, 2, 0);
        idle(1);
        wr(8'h04, 32'h1);
        measure(5);
        chk(mhi[0] == 3, "R10 pending taken while disabled", mhi[0], 3);

        // R11 independent channels
        cfg(2, 0, 2, 6, 3, 2, 0);
        cfg(3, 0, 6, 8, 3, 2, 0);
        wr(8'h04, 32'hC);
        measure(24);
        chk(mhi[2] == 8, "R11 ch2 independent", mhi[2], 8);
        chk(mhi[3] == 18, "R11 ch3 independent", mhi[3], 18);
        chk(mhi[0] == 15, "R11 ch0 undisturbed", mhi[0], 15);

        // constrained random phase, checked by the model every cycle
        for (int it = 0; it < 4000; it++) begin
            int ch;
            int op;
            ch = int'($urandom % NCH);
            op = int'($urandom % 10);
            case (op)
                0, 1: wr(base_of(ch), {16'($urandom % 16), 16'($urandom % 8)});
                2, 3: wr(base_of(ch) + 16, {9'd0, 3'($urandom % 3), 2'($urandom % 4),
                                            2'($urandom % 4), 16'($urandom % 12)});
                4:    wr(8'h04, 32'(1 << ch));
                5:    wr(8'h08, 32'(1 << ch));
                6: begin
                    logic [31:0] e;
                    e = m_wst[ch];
                    rd(base_of(ch), d);
                    chk(d == e, "R3 random window readback", d, e);
                end
                default: idle(1 + int'($urandom % 6));
            endcase
        end

        idle(4);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule